// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block lets a host reach a serial flash through a JTAG chain. While the TAP is in SHIFT-DR with the user instruction selected, TCK becomes the flash clock, TDI becomes MOSI and sampled MISO comes back on TDO. The TAP controller is not part of the block; it only sees the TAP state qualifiers, TCK and TDI.

Each scan carries its own framing. Zeros that arrive first, such as those from cleared bypass registers of other devices, are skipped. A single 1 bit marks the start of a frame. The next 32 bits, sent least significant bit first, give the payload length minus one. The payload is command, address and data, with each byte sent most significant bit first by the host. The block opens chip select for exactly that many TCK cycles. Before it reaches the flash, the host adds one dummy read bit for each enabled TAP in the chain. It picks 3- or 4-byte addressing itself, and a plain 0x03 read always uses 3 bytes.

Top module: `jspi_bridge`

## Requirements
- R1: After reset, spi_cs_no is 1, spi_sck_o is 0, spi_mosi_o is 0 and tdo_o is 0.
- R2: Zero bits on TDI before the first 1 in a scan are skipped. A scan that holds only zeros never drives chip select low.
- R3: After the marker bit, 32 TDI bits form a length L, least significant bit first. The frame then carries exactly L+1 payload bits, counted as SCK rising edges.
- R4: spi_cs_no goes low at the falling TCK edge after the last header bit. It stays low for exactly the L+1 rising TCK edges of the payload and is high again at the next falling edge.
- R5: While chip select is low, spi_mosi_o equals tdi_i. On each SCK rising edge the flash receives the payload bits in the order they were shifted.
- R6: spi_sck_o follows tck_i only while chip select is low and is 0 otherwise.
- R7: tdo_o holds the spi_miso_i value sampled at the most recent rising TCK edge with chip select low, and keeps that value while chip select is high.
- R8: The bridge acts only while user_sel_i and shift_dr_i are both 1. When either drops, chip select goes high at once and the frame is abandoned. The next scan needs a new marker.
- R9: While tlr_i is 1, the parser returns to waiting for a marker, even in the middle of a header.
- R10: Once a frame's payload is done, any further TDI bits in the same scan are ignored, including 1 bits. So are 1 bits inside the header or payload: they never restart a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | JTAG test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdi_i | input | 1 | JTAG serial data in |
| tdo_o | output | 1 | JTAG serial data out (captured MISO) |
| user_sel_i | input | 1 | User instruction is loaded in the IR |
| shift_dr_i | input | 1 | TAP is in SHIFT-DR |
| tlr_i | input | 1 | TAP is in test-logic-reset |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Flash serial clock |
| spi_mosi_o | output | 1 | Flash serial data in |
| spi_miso_i | input | 1 | Flash serial data out |

## Verification
The test sweeps the number of leading bypass zeros against payload lengths of 1, 2, 9, 40 and 257 bits. This separates an off-by-one in the length counter from header bit-order errors, since length 257 sets header bits above the lowest byte. Payload and trailing patterns contain 1 bits, so a parser that restarts on a stray 1 would give the wrong edge count. Four more scans each cover one case: a scan of only zeros, a scan without the user instruction, a scan cut short mid-payload and then followed by a clean frame, and a test-logic-reset in the middle of a header followed by a new frame in the same scan. For every frame, TDO is compared with the MISO stream delayed by one bit.

// File: rtl/jspi_pkg.sv
package jspi_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_PAY  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/jspi_frame_parser.sv
module jspi_frame_parser
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic   tck_i,
  input  logic   rst_ni,
  input  logic   active_i,
  input  logic   tdi_i,
  output phase_e phase_o
);
  localparam int IDX_W = $clog2(LEN_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN_W - 1);

  phase_e           ph_q;
  logic [LEN_W-1:0] hdr_q;
  logic [LEN_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      hdr_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!active_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (tdi_i) begin
          ph_q  <= PH_HDR;
          idx_q <= '0;
        end
        PH_HDR: begin
          // header arrives LSB first: shift right, newest bit on top
          hdr_q <= {tdi_i, hdr_q[LEN_W-1:1]};
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            cnt_q <= {tdi_i, hdr_q[LEN_W-1:1]};
            ph_q  <= PH_PAY;
          end
        end
        PH_PAY: begin
          if (cnt_q == '0) ph_q <= PH_DONE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_DONE;
      endcase
    end
  end

  assign phase_o = ph_q;

  assert_cnt_step_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ph_q == PH_PAY && active_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_idle_hold_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE && !tdi_i) |=> (ph_q == PH_IDLE));
  assert_exit_clear_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !active_i |=> (ph_q == PH_IDLE && cnt_q == '0));
  assert_done_sticky_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ph_q == PH_DONE && active_i) |=> (ph_q == PH_DONE));
endmodule

// File: rtl/jspi_cs_ctrl.sv
module jspi_cs_ctrl
  import jspi_pkg::*;
(
  input  logic   tck_i,
  input  logic   rst_ni,
  input  logic   active_i,
  input  phase_e phase_i,
  input  logic   tdi_i,
  output logic   spi_cs_no,
  output logic   spi_sck_o,
  output logic   spi_mosi_o
);
  logic cs_n_q;

  // falling-edge update keeps SCK free of a partial pulse at frame edges
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) cs_n_q <= 1'b1;
    else         cs_n_q <= (phase_i != PH_PAY);
  end

  assign spi_cs_no  = cs_n_q | ~active_i;
  assign spi_sck_o  = tck_i & ~spi_cs_no;
  assign spi_mosi_o = tdi_i & ~spi_cs_no;

  assert_cs_in_pay_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !spi_cs_no |-> (phase_i == PH_PAY));
  assert_cs_after_done_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (phase_i == PH_DONE) |-> spi_cs_no);
endmodule

// File: rtl/jspi_miso_capture.sv
module jspi_miso_capture (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic miso_i,
  output logic tdo_o
);
  logic miso_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)     miso_q <= 1'b0;
    else if (!cs_ni) miso_q <= miso_i;
  end

  assign tdo_o = miso_q;

  assert_tdo_hold_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    cs_ni |=> $stable(tdo_o));
endmodule

// File: rtl/jspi_bridge.sv
module jspi_bridge
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tdi_i,
  output logic tdo_o,
  input  logic user_sel_i,
  input  logic shift_dr_i,
  input  logic tlr_i,
  output logic spi_cs_no,
  output logic spi_sck_o,
  output logic spi_mosi_o,
  input  logic spi_miso_i
);
  logic   active;
  phase_e phase;

  assign active = user_sel_i & shift_dr_i & ~tlr_i;

  jspi_frame_parser #(.LEN_W(LEN_W)) i_parser (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .tdi_i   (tdi_i),
    .phase_o (phase)
  );

  jspi_cs_ctrl i_cs (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .phase_i   (phase),
    .tdi_i     (tdi_i),
    .spi_cs_no (spi_cs_no),
    .spi_sck_o (spi_sck_o),
    .spi_mosi_o(spi_mosi_o)
  );

  jspi_miso_capture i_cap (
    .tck_i (tck_i),
    .rst_ni(rst_ni),
    .cs_ni (spi_cs_no),
    .miso_i(spi_miso_i),
    .tdo_o (tdo_o)
  );
endmodule

// File: tb/test_jspi_bridge.sv
module test_jspi_bridge;
  logic tck = 1'b0, rst_n = 1'b0, tdi = 1'b0, sel = 1'b0, shift = 1'b0, tlr = 1'b0, miso = 1'b0;
  logic tdo, cs_n, sck, mosi;

  jspi_bridge i_jspi_bridge (
    .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .tdo_o(tdo),
    .user_sel_i(sel), .shift_dr_i(shift), .tlr_i(tlr),
    .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  always #2 tck = ~tck;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit sel_v = 1;
  int sck_cnt, sck_hi, cs_low_cnt, tdo_err, cyc;
  bit mon_en = 0;
  bit exp_tdo = 0;
  bit mos [0:511];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // flash model: new MISO bit each falling edge
  always @(negedge tck) begin
    cyc++;
    miso <= ((cyc % 7) < 3) ^ ((cyc / 16) % 2 == 1);
  end

  always @(posedge tck) begin
    if (!cs_n && rst_n) begin
      cs_low_cnt++;
      exp_tdo = miso;
    end
  end

  always @(negedge tck) if (mon_en && tdo !== exp_tdo) tdo_err++;

  always @(posedge sck) begin
    if (sck_cnt < 512) mos[sck_cnt] = mosi;
    sck_cnt++;
    if (cs_n) sck_hi++;
  end

  function automatic bit pay(input int i, input int seed);
    return ((i * 5 + seed) % 7) < 3;
  endfunction

  task automatic clr();
    sck_cnt = 0; sck_hi = 0; cs_low_cnt = 0; tdo_err = 0;
  endtask

  task automatic drive(input bit b, input bit s);
    @(negedge tck);
    tdi = b; shift = s; sel = sel_v;
  endtask

  task automatic body(input int lead, input int nbits, input int cut, input int seed);
    int n;
    n = (cut < nbits) ? cut : nbits;
    for (int i = 0; i < lead; i++) drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    for (int k = 0; k < 32; k++) drive(1'b1 & ((nbits - 1) >> k), 1'b1);
    for (int i = 0; i < n; i++) drive(pay(i, seed), 1'b1);
    if (cut >= nbits) for (int t = 0; t < 5; t++) drive(t != 1 && t != 4, 1'b1);
    drive(1'b0, 1'b0); drive(1'b0, 1'b0); drive(1'b0, 1'b0);
  endtask

  task automatic frame_chk(input int n, input int seed, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < n && i < 512; i++) if (mos[i] != pay(i, seed)) bad++;
    chk(sck_cnt == n, {tag, " R3 R10 sck edges"}, sck_cnt, n);
    chk(cs_low_cnt == n, {tag, " R4 cs low cycles"}, cs_low_cnt, n);
    chk(bad == 0, {tag, " R5 mosi mismatches"}, bad, 0);
    chk(sck_hi == 0, {tag, " R6 sck while cs high"}, sck_hi, 0);
    chk(tdo_err == 0, {tag, " R7 tdo mismatches"}, tdo_err, 0);
    chk(cs_n == 1'b1, {tag, " R4 cs idle after frame"}, cs_n, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int lens [5] = '{1, 2, 9, 40, 257};
    int leads [3] = '{0, 1, 3};
    #9;
    chk(cs_n == 1'b1, "R1 cs after reset", cs_n, 1);
    chk(sck == 1'b0, "R1 sck after reset", sck, 0);
    chk(mosi == 1'b0, "R1 mosi after reset", mosi, 0);
    chk(tdo == 1'b0, "R1 tdo after reset", tdo, 0);
    @(negedge tck); rst_n = 1'b1; mon_en = 1'b1;

    // sweep of lead zeros against payload length
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 5; b++) begin
        clr();
        body(leads[a], lens[b], 100000, a * 5 + b);
        frame_chk(lens[b], a * 5 + b, "sweep");
      end

    // R2: zeros only
    clr();
    for (int i = 0; i < 50; i++) drive(1'b0, 1'b1);
    drive(1'b0, 1'b0); drive(1'b0, 1'b0);
    chk(sck_cnt == 0, "R2 zero scan sck edges", sck_cnt, 0);
    chk(cs_low_cnt == 0, "R2 zero scan cs low", cs_low_cnt, 0);

    // R8: user instruction not selected
    clr(); sel_v = 0;
    body(1, 16, 100000, 2);
    chk(sck_cnt == 0, "R8 unselected sck edges", sck_cnt, 0);
    chk(cs_low_cnt == 0, "R8 unselected cs low", cs_low_cnt, 0);
    sel_v = 1;

    // R8: scan cut mid-payload, then a clean frame
    clr();
    body(1, 40, 12, 5);
    frame_chk(12, 5, "R8 cut");
    clr();
    body(0, 16, 100000, 6);
    frame_chk(16, 6, "R8 after cut");

    // R9: test-logic-reset mid-header, new frame in the same scan
    clr();
    drive(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1);
    @(negedge tck); tlr = 1'b1; tdi = 1'b0;
    @(negedge tck); tlr = 1'b0;
    body(2, 8, 100000, 3);
    frame_chk(8, 3, "R9 tlr");

    finished = 1;
    summary();
    $finish;
  end
endmodule